// File: doc/BRIEF.md
# Chunked FIFO Transfer Sequencer

This block runs one byte-counted transfer at a time through a 512-byte data FIFO. One side of the FIFO is the host side, where software or an external DMA engine writes or reads bytes. The other side is a device-side byte port that feeds the card interface. Software writes a control word that holds a byte count, a direction bit, a few mode flags and a start bit. While the transfer runs, the block moves bytes between the FIFO and the device port and tracks how many bytes remain.

The host paces itself on event pulses. A buffer-available pulse marks each 512-byte chunk. On a read it fires when the device has delivered a full chunk into the FIFO. On a write it fires when the FIFO is empty and the host owes the next chunk. A chunk at the end of the transfer that is shorter than 512 bytes raises the pulse at its own length. A done pulse marks that the whole count has passed through the FIFO. An error pulse marks a host overflow or underflow, and the transfer stops. Clearing the start bit aborts the transfer at once.

One start moves at most 128 KiB. Longer moves are split by software into several starts.

Top module: `cfx_xfer_seq`

## Requirements
- R1: After reset, `ctl_rdata` is zero and all three event outputs are low. `dev_rd_ready` and `dev_wr_valid` are also low.
- R2: `ctl_rdata` reads back the control word as follows. Bits 17:0 hold the remaining count. Bit 24 is the no-increment flag, bit 25 the 16-bit flag and bit 28 the DMA-mode flag. Bit 30 is the direction (1 = write toward the device). Bit 31 is the running/start bit. All other bits read 0.
- R3: A control write whose count field exceeds 0x20000 loads 0x20000 as the count.
- R4: In a read (bit 30 = 0), `dev_rd_ready` is high while the transfer runs, the FIFO holds fewer than 512 bytes and fewer than the count have been accepted. Accepted bytes appear in order at `host_rd_data`. Each `host_rd_en` on a non-empty FIFO removes one byte and lowers the count by one.
- R5: In a read, `evt_buf_avail` pulses for one cycle after every 512th byte that the device delivers. It also pulses after the last delivered byte when that byte ends a shorter chunk.
- R6: In a write, `evt_buf_avail` pulses once the FIFO is empty, the host has completed its previous chunk and bytes remain to be pushed. `dev_wr_valid`/`dev_wr_data` present the FIFO bytes in push order. Each accepted device byte lowers the count by one.
- R7: When the count reaches zero, `evt_done` pulses for one cycle. In that same cycle, bit 31 and the count both read 0.
- R8: A start with a count of zero raises `evt_done` in the next cycle, with no `evt_buf_avail` and with bit 31 reading 0.
- R9: A host push while a write runs and the FIFO holds 512 bytes, or a host pop while a read runs and the FIFO is empty, raises `evt_err` for one cycle. It clears bit 31 and raises no `evt_done`.
- R10: A control write with bit 31 = 0 while running stops the transfer. No done or buffer-available event follows, and both device handshakes go low.
- R11: While no transfer runs, host pushes and pops raise no event and the device handshakes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word written |
| ctl_rdata | output | 32 | Control readback with remaining count |
| host_wr_en | input | 1 | Host pushes one byte (write transfer) |
| host_wr_data | input | 8 | Byte pushed by host |
| host_rd_en | input | 1 | Host pops one byte (read transfer) |
| host_rd_data | output | 8 | FIFO head byte |
| dev_rd_valid | input | 1 | Device offers a byte (read transfer) |
| dev_rd_data | input | 8 | Byte from device |
| dev_rd_ready | output | 1 | Sequencer accepts device byte |
| dev_wr_valid | output | 1 | Sequencer offers a byte to device |
| dev_wr_data | output | 8 | Byte to device |
| dev_wr_ready | input | 1 | Device accepts byte |
| evt_buf_avail | output | 1 | Chunk ready / space free pulse |
| evt_done | output | 1 | Transfer complete pulse |
| evt_err | output | 1 | Overflow/underflow pulse |

## Verification
The hardest state to reach is a full FIFO with host bytes still owed. Only then can a host push overflow the FIFO on a write. The stimulus holds `dev_wr_ready` low and waits for the first buffer-available pulse. It then pushes a whole chunk of a 600-byte transfer and offers one more byte. Read transfers of 1200 bytes (a short tail chunk) and 2000 bytes, plus a 700-byte write under irregular device readiness, exercise chunk boundaries and FIFO backpressure. Every cycle is compared against a queue-based reference model.

// File: rtl/cfx_seq_pkg.sv
package cfx_seq_pkg;
   localparam int unsigned CTRL_W    = 32;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned POS_START = 31;
   localparam int unsigned POS_WRITE = 30;
   localparam int unsigned POS_DMA   = 28;
   localparam int unsigned POS_W16   = 25;
   localparam int unsigned POS_NOINC = 24;

   typedef struct packed {
      logic noinc;
      logic w16;
      logic dma;
      logic wr;
   } xfer_mode_t;
endpackage

// File: rtl/cfx_ctrl_reg.sv
module cfx_ctrl_reg
   import cfx_seq_pkg::*;
#(
   parameter int unsigned CNT_W   = 18,
   parameter int unsigned MAX_CNT = 131072
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              dec,
   input  logic              fault,
   output logic              run,
   output xfer_mode_t        mode,
   output logic [CNT_W-1:0]  load_cnt,
   output logic [CTRL_W-1:0] rdata,
   output logic              evt_done,
   output logic              evt_err
);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_CNT);

   if (CNT_W > POS_NOINC) begin : g_bad_cnt_w
      $error("count field overlaps the flag bits");
   end
   if (MAX_CNT >= (64'd1 << CNT_W)) begin : g_bad_cap
      $error("MAX_CNT does not fit the count field");
   end

   logic [CNT_W-1:0] remaining;
   logic [CNT_W-1:0] raw_cnt;

   assign raw_cnt  = wdata[CNT_W-1:0];
   assign load_cnt = (raw_cnt > CAP) ? CAP : raw_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= 1'b0;
         mode      <= '0;
         remaining <= '0;
         evt_done  <= 1'b0;
         evt_err   <= 1'b0;
      end else if (we) begin
         mode.noinc <= wdata[POS_NOINC];
         mode.w16   <= wdata[POS_W16];
         mode.dma   <= wdata[POS_DMA];
         mode.wr    <= wdata[POS_WRITE];
         remaining  <= load_cnt;
         run        <= wdata[POS_START] && (load_cnt != '0);
         evt_done   <= wdata[POS_START] && (load_cnt == '0);
         evt_err    <= 1'b0;
      end else begin
         evt_done <= 1'b0;
         evt_err  <= 1'b0;
         if (run) begin
            if (dec) remaining <= remaining - 1'b1;
            if (fault) begin
               run     <= 1'b0;
               evt_err <= 1'b1;
            end else if (dec && remaining == CNT_W'(1)) begin
               run      <= 1'b0;
               evt_done <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      rdata                 = '0;
      rdata[CNT_W-1:0]      = remaining;
      rdata[POS_NOINC]      = mode.noinc;
      rdata[POS_W16]        = mode.w16;
      rdata[POS_DMA]        = mode.dma;
      rdata[POS_WRITE]      = mode.wr;
      rdata[POS_START]      = run;
   end
endmodule

// File: rtl/cfx_byte_fifo.sv
module cfx_byte_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 512
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned LW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("FIFO depth must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_n, rp_n;
   logic [LW-1:0] lvl;
   logic          do_push, do_pop;

   assign full    = (lvl == LW'(DEPTH));
   assign empty   = (lvl == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_n = wp + 1'b1;
      assign rp_n = rp + 1'b1;
   end else begin : g_wrap
      assign wp_n = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_n = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         lvl <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         lvl <= '0;
      end else begin
         if (do_push) wp <= wp_n;
         if (do_pop)  rp <= rp_n;
         lvl <= lvl + LW'(do_push) - LW'(do_pop);
      end
   end
endmodule

// File: rtl/cfx_chunk_track.sv
module cfx_chunk_track #(
   parameter int unsigned CNT_W = 18,
   parameter int unsigned CHUNK = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             run,
   input  logic             wr_dir,
   input  logic             step,
   input  logic             fifo_empty,
   output logic             left_nz,
   output logic             evt_buf_avail
);
   localparam int unsigned CW = (CHUNK > 1) ? $clog2(CHUNK) : 1;

   if (CHUNK < 2) begin : g_bad_chunk
      $error("chunk size must be at least 2");
   end

   logic [CNT_W-1:0] left;
   logic [CW-1:0]    fill;
   logic             armed;
   logic             chunk_end;
   logic             space_cond;

   assign left_nz    = (left != '0);
   assign chunk_end  = (fill == CW'(CHUNK - 1)) || (left == CNT_W'(1));
   assign space_cond = run && wr_dir && fifo_empty && armed && left_nz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left          <= '0;
         fill          <= '0;
         armed         <= 1'b0;
         evt_buf_avail <= 1'b0;
      end else if (load) begin
         left          <= load_cnt;
         fill          <= '0;
         armed         <= 1'b1;
         evt_buf_avail <= 1'b0;
      end else begin
         if (step) begin
            left <= left - 1'b1;
            fill <= chunk_end ? '0 : fill + 1'b1;
         end
         if (wr_dir) begin
            evt_buf_avail <= space_cond;
            if (step && chunk_end) armed <= 1'b1;
            else if (space_cond)   armed <= 1'b0;
         end else begin
            evt_buf_avail <= step && chunk_end;
         end
      end
   end
endmodule

// File: rtl/cfx_xfer_seq.sv
module cfx_xfer_seq
   import cfx_seq_pkg::*;
#(
   parameter int unsigned FIFO_BYTES = 512,
   parameter int unsigned CNT_W      = 18,
   parameter int unsigned MAX_CNT    = 131072
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [CTRL_W-1:0] ctl_wdata,
   output logic [CTRL_W-1:0] ctl_rdata,
   input  logic              host_wr_en,
   input  logic [BYTE_W-1:0] host_wr_data,
   input  logic              host_rd_en,
   output logic [BYTE_W-1:0] host_rd_data,
   input  logic              dev_rd_valid,
   input  logic [BYTE_W-1:0] dev_rd_data,
   output logic              dev_rd_ready,
   output logic              dev_wr_valid,
   output logic [BYTE_W-1:0] dev_wr_data,
   input  logic              dev_wr_ready,
   output logic              evt_buf_avail,
   output logic              evt_done,
   output logic              evt_err
);
   if (MAX_CNT < FIFO_BYTES) begin : g_bad_max
      $error("largest count must cover at least one chunk");
   end

   logic              run;
   xfer_mode_t        mode;
   logic [CNT_W-1:0]  load_cnt;
   logic              fifo_full, fifo_empty, left_nz;
   logic [BYTE_W-1:0] fifo_rdata, fifo_wdata;
   logic              push_dev, push_host, pop_host, pop_dev;
   logic              fault, dec, step, wr_dir;

   assign wr_dir       = mode.wr;
   assign dev_rd_ready = run && !wr_dir && !fifo_full && left_nz;
   assign dev_wr_valid = run && wr_dir && !fifo_empty;
   assign dev_wr_data  = fifo_rdata;
   assign host_rd_data = fifo_rdata;

   assign push_dev  = dev_rd_valid && dev_rd_ready;
   assign push_host = run && wr_dir && host_wr_en && !fifo_full && left_nz;
   assign pop_host  = run && !wr_dir && host_rd_en && !fifo_empty;
   assign pop_dev   = dev_wr_valid && dev_wr_ready;
   assign fault     = run && (wr_dir ? (host_wr_en && fifo_full)
                                     : (host_rd_en && fifo_empty));
   assign dec        = wr_dir ? pop_dev : pop_host;
   assign step       = wr_dir ? push_host : push_dev;
   assign fifo_wdata = wr_dir ? host_wr_data : dev_rd_data;

   cfx_ctrl_reg #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ctl_we),
      .wdata    (ctl_wdata),
      .dec      (dec),
      .fault    (fault),
      .run      (run),
      .mode     (mode),
      .load_cnt (load_cnt),
      .rdata    (ctl_rdata),
      .evt_done (evt_done),
      .evt_err  (evt_err)
   );

   cfx_byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_BYTES)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (ctl_we),
      .push  (push_dev || push_host),
      .wdata (fifo_wdata),
      .pop   (pop_host || pop_dev),
      .rdata (fifo_rdata),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   cfx_chunk_track #(.CNT_W(CNT_W), .CHUNK(FIFO_BYTES)) u_chunk (
      .clk           (clk),
      .rst_n         (rst_n),
      .load          (ctl_we),
      .load_cnt      (load_cnt),
      .run           (run),
      .wr_dir        (wr_dir),
      .step          (step),
      .fifo_empty    (fifo_empty),
      .left_nz       (left_nz),
      .evt_buf_avail (evt_buf_avail)
   );
endmodule

// File: rtl/cfx_xfer_seq_chk.sv
module cfx_xfer_seq_chk #(
   parameter int unsigned CNT_W   = 18,
   parameter int unsigned MAX_CNT = 131072
) (
   input logic        clk,
   input logic        rst_n,
   input logic        ctl_we,
   input logic [31:0] ctl_wdata,
   input logic [31:0] ctl_rdata,
   input logic        dev_rd_ready,
   input logic        dev_wr_valid,
   input logic        evt_buf_avail,
   input logic        evt_done,
   input logic        evt_err
);
   logic [CNT_W-1:0] rem;
   assign rem = ctl_rdata[CNT_W-1:0];

   // R7
   done_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done |-> (!ctl_rdata[31] && rem == '0));
   // R9
   err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_err |-> (!ctl_rdata[31] && !evt_done));
   // R3
   count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (rem <= CNT_W'(MAX_CNT)));
   // R8
   zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[31] && ctl_wdata[CNT_W-1:0] == '0) |=> (evt_done && !evt_buf_avail));
   // R10
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !ctl_wdata[31]) |=> (!ctl_rdata[31] && !evt_done && !evt_buf_avail));
   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[31] |-> (!dev_rd_ready && !dev_wr_valid));
   // R4
   rd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rd_ready |-> !ctl_rdata[30]);
   // R6
   wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_wr_valid |-> ctl_rdata[30]);
   // R5
   event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt_buf_avail, evt_done}));
   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we |=> (rem == $past(rem) || rem == $past(rem) - 1'b1));
endmodule

bind cfx_xfer_seq cfx_xfer_seq_chk #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctl_we        (ctl_we),
   .ctl_wdata     (ctl_wdata),
   .ctl_rdata     (ctl_rdata),
   .dev_rd_ready  (dev_rd_ready),
   .dev_wr_valid  (dev_wr_valid),
   .evt_buf_avail (evt_buf_avail),
   .evt_done      (evt_done),
   .evt_err       (evt_err)
);

// File: tb/sim_cfx_xfer_seq.sv
module sim_cfx_xfer_seq;
   localparam int PERIOD = 10;
   localparam int FIFO_N = 512;
   localparam int CAP    = 131072;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic [31:0] ctl_rdata;
   logic        host_wr_en = 1'b0;
   logic [7:0]  host_wr_data = '0;
   logic        host_rd_en = 1'b0;
   logic [7:0]  host_rd_data;
   logic        dev_rd_valid = 1'b0;
   logic [7:0]  dev_rd_data = '0;
   logic        dev_rd_ready;
   logic        dev_wr_valid;
   logic [7:0]  dev_wr_data;
   logic        dev_wr_ready = 1'b0;
   logic        evt_buf_avail, evt_done, evt_err;

   always #(PERIOD/2) clk = ~clk;

   cfx_xfer_seq u0 (.*);

   int nchk = 0, nerr = 0;
   int bav_seen = 0, done_seen = 0, err_seen = 0;

   // reference model state
   bit m_run, m_wr, m_noinc, m_w16, m_dma, m_armed;
   bit m_bav, m_done, m_err, m_took_dev, m_took_host;
   int m_rem, m_left, m_chunk;
   byte unsigned q[$];

   task automatic chk(bit ok, string tag, longint act, longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rdata();
      logic [31:0] r = '0;
      r[17:0] = 18'(m_rem);
      r[24] = m_noinc; r[25] = m_w16; r[28] = m_dma; r[30] = m_wr; r[31] = m_run;
      return r;
   endfunction

   task automatic compare();
      bit e_rdy = m_run && !m_wr && q.size() < FIFO_N && m_left != 0;
      bit e_wv  = m_run && m_wr && q.size() != 0;
      chk(ctl_rdata == exp_rdata(), "R2 readback", ctl_rdata, exp_rdata());
      chk(evt_buf_avail == m_bav, "R5/R6 buf_avail", evt_buf_avail, m_bav);
      chk(evt_done == m_done, "R7 done", evt_done, m_done);
      chk(evt_err == m_err, "R9 err", evt_err, m_err);
      chk(dev_rd_ready == e_rdy, "R4 dev_rd_ready", dev_rd_ready, e_rdy);
      chk(dev_wr_valid == e_wv, "R6 dev_wr_valid", dev_wr_valid, e_wv);
      if (e_wv) chk(dev_wr_data == q[0], "R6 dev_wr_data", dev_wr_data, q[0]);
      if (m_run && !m_wr && q.size() > 0)
         chk(host_rd_data == q[0], "R4 host_rd_data", host_rd_data, q[0]);
      if (evt_buf_avail) bav_seen++;
      if (evt_done) done_seen++;
      if (evt_err) err_seen++;
   endtask

   task automatic model_step();
      bit empty = (q.size() == 0);
      bit full  = (q.size() == FIFO_N);
      bit nb = 0, nd = 0, ne = 0, dec = 0, fault = 0;
      m_took_dev = 0; m_took_host = 0;
      if (ctl_we) begin
         int c = int'(ctl_wdata[17:0]);
         if (c > CAP) c = CAP;
         m_noinc = ctl_wdata[24]; m_w16 = ctl_wdata[25];
         m_dma = ctl_wdata[28]; m_wr = ctl_wdata[30];
         m_rem = c; m_left = c; m_chunk = 0; m_armed = 1;
         m_run = ctl_wdata[31] && c != 0;
         nd = ctl_wdata[31] && c == 0;
         q.delete();
      end else if (m_run) begin
         if (!m_wr) begin
            bit pushd = dev_rd_valid && !full && m_left != 0;
            bit poph  = host_rd_en && !empty;
            fault = host_rd_en && empty;
            if (poph) void'(q.pop_front());
            if (pushd) begin
               nb = (m_chunk == FIFO_N-1) || (m_left == 1);
               m_chunk = nb ? 0 : m_chunk + 1;
               m_left--;
               q.push_back(dev_rd_data);
               m_took_dev = 1;
            end
            dec = poph;
         end else begin
            bit take  = !empty && dev_wr_ready;
            bit pushh = host_wr_en && !full && m_left != 0;
            bit cond  = empty && m_armed && m_left != 0;
            bit fin   = 0;
            fault = host_wr_en && full;
            nb = cond;
            if (take) void'(q.pop_front());
            if (pushh) begin
               fin = (m_chunk == FIFO_N-1) || (m_left == 1);
               m_chunk = fin ? 0 : m_chunk + 1;
               m_left--;
               q.push_back(host_wr_data);
               m_took_host = 1;
            end
            if (fin) m_armed = 1;
            else if (cond) m_armed = 0;
            dec = take;
         end
         if (dec) m_rem--;
         if (fault) begin
            m_run = 0; ne = 1;
         end else if (dec && m_rem == 0) begin
            m_run = 0; nd = 1;
         end
      end
      m_bav = nb; m_done = nd; m_err = ne;
   endtask

   task automatic tick();
      #1 compare();
      @(posedge clk);
      if (rst_n) model_step();
      @(negedge clk);
   endtask

   task automatic ctl_write(logic [31:0] w);
      ctl_we = 1'b1; ctl_wdata = w;
      tick();
      ctl_we = 1'b0; ctl_wdata = '0;
   endtask

   task automatic clear_counts();
      bav_seen = 0; done_seen = 0; err_seen = 0;
   endtask

   task automatic idle_inputs();
      host_wr_en = 0; host_rd_en = 0; dev_rd_valid = 0; dev_wr_ready = 0;
   endtask

   task automatic run_read(int n, int gap);
      int dsent = 0;
      int k = 0;
      clear_counts();
      ctl_write(32'h8000_0000 | 32'(n));
      while (m_run && k < 40000) begin
         dev_rd_valid = 1'b1;
         dev_rd_data  = 8'(dsent * 7 + 3);
         host_rd_en   = (k % gap == 0) && (q.size() > 0);
         tick();
         if (m_took_dev) dsent++;
         k++;
      end
      idle_inputs();
      tick();
   endtask

   task automatic run_write(int n);
      int hsent = 0;
      int credit = 0;
      int k = 0;
      clear_counts();
      ctl_write(32'hC000_0000 | 32'(n));
      while (m_run && k < 40000) begin
         if (evt_buf_avail) begin
            int more = n - hsent - credit;
            credit += (more > FIFO_N) ? FIFO_N : more;
         end
         host_wr_en   = credit > 0;
         host_wr_data = 8'(hsent * 5 + 1);
         dev_wr_ready = (k % 3) != 0;
         tick();
         if (m_took_host) begin hsent++; credit--; end
         k++;
      end
      idle_inputs();
      tick();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nerr++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      #1;
      chk(ctl_rdata == 32'h0, "R1 rdata", ctl_rdata, 0);
      chk(!evt_buf_avail && !evt_done && !evt_err, "R1 events", {evt_buf_avail, evt_done, evt_err}, 0);
      chk(!dev_rd_ready && !dev_wr_valid, "R1 handshakes", {dev_rd_ready, dev_wr_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: field positions, no start
      ctl_write(32'h5300_0005);
      #1 chk(ctl_rdata == 32'h5300_0005, "R2 fields", ctl_rdata, 32'h5300_0005);
      tick();

      // R11: idle pushes and pops do nothing
      clear_counts();
      host_wr_en = 1; host_rd_en = 1; dev_rd_valid = 1; dev_wr_ready = 1;
      repeat (6) tick();
      idle_inputs();
      chk(bav_seen + done_seen + err_seen == 0, "R11 idle events", bav_seen + done_seen + err_seen, 0);

      // R4 R5 R7: read with short tail chunk
      run_read(1200, 2);
      chk(bav_seen == 3, "R5 read chunks 1200", bav_seen, 3);
      chk(done_seen == 1, "R7 read done 1200", done_seen, 1);
      chk(ctl_rdata == 32'h0, "R7 read end rdata", ctl_rdata, 0);

      // R4 R5: faster host, exact multiple of chunk plus tail
      run_read(2000, 1);
      chk(bav_seen == 4, "R5 read chunks 2000", bav_seen, 4);
      chk(done_seen == 1, "R7 read done 2000", done_seen, 1);

      // R6 R7: write
      run_write(700);
      chk(bav_seen == 2, "R6 write chunks 700", bav_seen, 2);
      chk(done_seen == 1, "R7 write done 700", done_seen, 1);
      chk(err_seen == 0, "R9 no write err", err_seen, 0);

      // R8: zero count
      clear_counts();
      ctl_write(32'h8000_0000);
      #1;
      chk(evt_done == 1'b1, "R8 zero done", evt_done, 1);
      chk(evt_buf_avail == 1'b0, "R8 zero no buf", evt_buf_avail, 0);
      chk(ctl_rdata[31] == 1'b0, "R8 zero start bit", ctl_rdata[31], 0);
      tick();

      // R3: clamp, then R10 abort
      clear_counts();
      ctl_write(32'h8003_FFFF);
      #1 chk(ctl_rdata[17:0] == 18'h20000, "R3 clamp", ctl_rdata[17:0], 18'h20000);
      dev_rd_valid = 1;
      repeat (20) tick();
      dev_rd_valid = 0;
      ctl_write(32'h0000_0000);
      repeat (4) tick();
      chk(done_seen == 0 && bav_seen == 0, "R10 abort quiet", done_seen + bav_seen, 0);
      chk(ctl_rdata[31] == 1'b0, "R10 abort start", ctl_rdata[31], 0);
      chk(!dev_rd_ready, "R10 abort ready", dev_rd_ready, 0);

      // R9: read underflow
      clear_counts();
      ctl_write(32'h8000_000A);
      host_rd_en = 1;
      tick();
      host_rd_en = 0;
      tick();
      chk(err_seen == 1, "R9 underflow err", err_seen, 1);
      chk(done_seen == 0, "R9 underflow no done", done_seen, 0);
      chk(ctl_rdata[31] == 1'b0, "R9 underflow start", ctl_rdata[31], 0);

      // R9: write overflow
      clear_counts();
      ctl_write(32'hC000_0258);
      for (int i = 0; i < 10 && !evt_buf_avail; i++) tick();
      host_wr_en = 1;
      for (int i = 0; i < FIFO_N; i++) begin
         host_wr_data = 8'(i);
         tick();
      end
      host_wr_data = 8'hEE;
      tick();
      host_wr_en = 0;
      tick();
      chk(err_seen == 1, "R9 overflow err", err_seen, 1);
      chk(done_seen == 0, "R9 overflow no done", done_seen, 0);
      chk(ctl_rdata[31] == 1'b0, "R9 overflow start", ctl_rdata[31], 0);
      repeat (2) tick();

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule